// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block tells a flash controller when an embedded program or erase operation inside a NOR flash device has finished. It does this by polling the data bus only. A start pulse latches the status address and a timeout count. The poller then issues pairs of back-to-back reads on a simple request/response read bus. After each pair it compares the toggle bit (bit 6) of the two returned words. While the device is busy, that bit flips on every read. Once the bit stops flipping, the operation is complete.

If the toggle bit is still flipping and the first read of the pair carries the time-limit-exceeded flag (bit 5), the device may have finished just between the two reads. For that reason the poller takes one more pair of reads before it reports an error. A free-running cycle counter bounds the whole poll. The finish is signalled with a one-cycle `done_o` pulse. A 2-bit result code stays on `result_o` until the next start.

States: `ST_IDLE` (waiting for start), `ST_ISSUE_FIRST` / `ST_WAIT_FIRST` (request and await the first read of a pair), `ST_ISSUE_SECOND` / `ST_WAIT_SECOND` (the same for the second read), and `ST_JUDGE` (compare the pair).

Transitions:
- `ST_IDLE` moves to `ST_ISSUE_FIRST` on a start with a non-zero timeout. On a start with a zero timeout it stays in `ST_IDLE` and finishes at once.
- Each issue state moves to its wait state.
- Each wait state moves on when `rd_valid_i` arrives.
- `ST_JUDGE` returns to `ST_ISSUE_FIRST` for a further pair or a re-check pair, or finishes to `ST_IDLE`.
- Any polling state finishes to `ST_IDLE` with a timeout result once the counter has expired. In `ST_JUDGE` a success or error verdict takes priority over the timeout.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, `done_o` and `rd_req_o` are low and `result_o` is 00.
- R2: Each poll step requests two reads of the latched start address. `rd_req_o` is a single-cycle strobe, and the second read is requested only after the first has returned on `rd_valid_i`.
- R3: If bit 6 is equal in the two words of a pair, the poll finishes with result 01 (success), whatever bit 5 holds.
- R4: If bit 6 differs and bit 5 of the first word is 0, another pair is read and no error is reported.
- R5: If bit 6 differs and bit 5 of the first word is 1, one re-check pair is read. If bit 6 is equal in the re-check pair, the result is 01.
- R6: If bit 6 still differs in the re-check pair, the poll finishes with result 10 (error).
- R7: Bit 5 set only in the second word of a pair does not start a re-check.
- R8: A start with a timeout of 0 gives `done_o` with result 11 in the cycle right after the start edge, and no read is requested.
- R9: A timeout of all ones disables the time limit, so a poll may run for any number of cycles.
- R10: The elapsed counter is cleared by start and advances once per busy cycle. When it exceeds the timeout the result is 11 (timeout). If no read ever returns, `done_o` rises on the edge timeout+2 after the start edge.
- R11: `done_o` is high for exactly one cycle. The result code is held afterwards until the next start, which sets it to 00 while polling.
- R12: Bits of the status word other than bits 5 and 6 have no effect on the outcome.
- R13: A start request while the poller is busy is ignored. The address and the time limit of the ongoing poll are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a poll (taken only when idle) |
| addr_i | input | AW | Status address to poll |
| timeout_i | input | TW | Cycle limit; 0 = immediate timeout, all ones = no limit |
| rd_req_o | output | 1 | Single-cycle read request strobe |
| rd_addr_o | output | AW | Read address (latched status address) |
| rd_valid_i | input | 1 | Read data returned this cycle |
| rd_data_i | input | DW | Returned status word |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 ongoing, 01 success, 10 error, 11 timeout |

## Verification
A read request appears in the cycle after the edge that enters an issue state. The bench's responder returns data one cycle after it sees the strobe. A zero-timeout finish shows on `done_o` right after the start edge. A timeout with no returning read shows exactly timeout+2 edges after the start edge. A pair verdict shows one edge after the second word is captured. The bench drives and samples only on falling edges and counts rising edges from the start edge, so each exact-cycle check compares against the edge index worked out above. Verdicts that depend on the responder's latency are checked by result code and by the number of read strobes, which the requirements fix exactly.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_ISSUE_FIRST  = 3'd1,
        ST_WAIT_FIRST   = 3'd2,
        ST_ISSUE_SECOND = 3'd3,
        ST_WAIT_SECOND  = 3'd4,
        ST_JUDGE        = 3'd5
    } poll_state_e;

    typedef enum logic [1:0] {
        RES_ONGOING = 2'b00,
        RES_SUCCESS = 2'b01,
        RES_ERROR   = 2'b10,
        RES_TIMEOUT = 2'b11
    } poll_result_e;

    typedef enum logic [1:0] {
        VD_COMPLETE,
        VD_FAULT,
        VD_AGAIN,
        VD_RECHECK
    } verdict_e;

    // Status word bit positions the poller decodes
    localparam int TOGGLE_BIT = 6;
    localparam int LIMIT_BIT  = 5;

endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] elapsed_q;
    logic [TW-1:0] limit_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            elapsed_q <= '0;
            limit_q   <= '0;
        end else if (clear_i) begin
            elapsed_q <= '0;
            limit_q   <= limit_i;
        end else if (run_i && (elapsed_q != CNT_MAX)) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // An all-ones limit never expires
    assign expired_o = (limit_q != CNT_MAX) && (elapsed_q > limit_q);

    AST_TIMER_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (elapsed_q == '0)); // R10

    AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clear_i && elapsed_q != CNT_MAX) |=> (elapsed_q == $past(elapsed_q) + 1'b1)); // R10

endmodule

// File: rtl/toggle_judge.sv
module toggle_judge
    import flash_poll_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] first_i,
    input  logic [DW-1:0] second_i,
    input  logic          recheck_i,
    output verdict_e      verdict_o
);
    logic toggled;

    assign toggled = first_i[TOGGLE_BIT] ^ second_i[TOGGLE_BIT];

    always_comb begin
        if (!toggled) begin
            verdict_o = VD_COMPLETE;
        end else if (recheck_i) begin
            verdict_o = VD_FAULT;
        end else if (first_i[LIMIT_BIT]) begin
            verdict_o = VD_RECHECK;
        end else begin
            verdict_o = VD_AGAIN;
        end
    end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import flash_poll_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] timeout_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o
);
    poll_state_e  state_q, state_d;
    poll_result_e result_q, fin_code;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] first_q, second_q;
    logic          recheck_q, recheck_d;
    logic          done_q;
    logic          finish, load, cap_first, cap_second;
    logic          expired, polling;
    verdict_e      verdict;

    assign polling = (state_q != ST_IDLE);

    poll_timer #(.TW(TW)) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (load),
        .run_i     (polling),
        .limit_i   (timeout_i),
        .expired_o (expired)
    );

    toggle_judge #(.DW(DW)) judge_i (
        .first_i   (first_q),
        .second_i  (second_q),
        .recheck_i (recheck_q),
        .verdict_o (verdict)
    );

    // Next-state and transition decisions
    always_comb begin
        state_d    = state_q;
        recheck_d  = recheck_q;
        finish     = 1'b0;
        fin_code   = RES_ONGOING;
        load       = 1'b0;
        cap_first  = 1'b0;
        cap_second = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (timeout_i == '0) begin
                        finish   = 1'b1;
                        fin_code = RES_TIMEOUT;
                    end else begin
                        load      = 1'b1;
                        recheck_d = 1'b0;
                        state_d   = ST_ISSUE_FIRST;
                    end
                end
            end
            ST_ISSUE_FIRST: begin
                if (expired) begin
                    finish   = 1'b1;
                    fin_code = RES_TIMEOUT;
                end else begin
                    state_d = ST_WAIT_FIRST;
                end
            end
            ST_WAIT_FIRST: begin
                if (rd_valid_i) begin
                    cap_first = 1'b1;
                    state_d   = ST_ISSUE_SECOND;
                end else if (expired) begin
                    finish   = 1'b1;
                    fin_code = RES_TIMEOUT;
                end
            end
            ST_ISSUE_SECOND: begin
                if (expired) begin
                    finish   = 1'b1;
                    fin_code = RES_TIMEOUT;
                end else begin
                    state_d = ST_WAIT_SECOND;
                end
            end
            ST_WAIT_SECOND: begin
                if (rd_valid_i) begin
                    cap_second = 1'b1;
                    state_d    = ST_JUDGE;
                end else if (expired) begin
                    finish   = 1'b1;
                    fin_code = RES_TIMEOUT;
                end
            end
            ST_JUDGE: begin
                unique case (verdict)
                    VD_COMPLETE: begin
                        finish   = 1'b1;
                        fin_code = RES_SUCCESS;
                    end
                    VD_FAULT: begin
                        finish   = 1'b1;
                        fin_code = RES_ERROR;
                    end
                    VD_RECHECK, VD_AGAIN: begin
                        if (expired) begin
                            finish   = 1'b1;
                            fin_code = RES_TIMEOUT;
                        end else begin
                            recheck_d = (verdict == VD_RECHECK);
                            state_d   = ST_ISSUE_FIRST;
                        end
                    end
                    default: begin
                        finish   = 1'b1;
                        fin_code = RES_ERROR;
                    end
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
        if (finish) begin
            state_d = ST_IDLE;
        end
    end

    // State register and captured data
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            recheck_q <= 1'b0;
            addr_q    <= '0;
            first_q   <= '0;
            second_q  <= '0;
            done_q    <= 1'b0;
            result_q  <= RES_ONGOING;
        end else begin
            state_q   <= state_d;
            recheck_q <= recheck_d;
            done_q    <= finish;
            if (load) begin
                addr_q <= addr_i;
            end
            if (cap_first) begin
                first_q <= rd_data_i;
            end
            if (cap_second) begin
                second_q <= rd_data_i;
            end
            if (finish) begin
                result_q <= fin_code;
            end else if (load) begin
                result_q <= RES_ONGOING;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_req_o  = (state_q == ST_ISSUE_FIRST) || (state_q == ST_ISSUE_SECOND);
        rd_addr_o = addr_q;
        busy_o    = polling;
        done_o    = done_q;
        result_o  = result_q;
    end

    AST_REQ_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o); // R2

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R11

    AST_DONE_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o != 2'b00)); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> $stable(result_o)); // R11

    AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(rd_addr_o)); // R13

    AST_ZERO_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && timeout_i == '0) |=> (done_o && result_o == 2'b11 && !busy_o)); // R8

    AST_MATCH_SUCCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_JUDGE && first_q[TOGGLE_BIT] == second_q[TOGGLE_BIT])
            |=> (done_o && result_o == 2'b01)); // R3

endmodule

// File: tb/flash_toggle_poller_tb_top.sv
module flash_toggle_poller_tb_top;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int NVEC = 9;

    // {busy reads N[45:34], DQ5 start F[45..][33:22], timeout[21:14], result[13:12], reads[11:0]}
    localparam logic [45:0] VECS [NVEC] = '{
        {12'd1,   12'hFFF, 8'd200, 2'b01, 12'd2},    // R3
        {12'd4,   12'hFFF, 8'd200, 2'b01, 12'd6},    // R4
        {12'd6,   12'hFFF, 8'd200, 2'b01, 12'd8},    // R4
        {12'd5,   12'd2,   8'd200, 2'b01, 12'd6},    // R5
        {12'd100, 12'd2,   8'd200, 2'b10, 12'd6},    // R6
        {12'd100, 12'd3,   8'd200, 2'b10, 12'd8},    // R7
        {12'd0,   12'd0,   8'd200, 2'b01, 12'd2},    // R3
        {12'd600, 12'hFFF, 8'd255, 2'b01, 12'd602},  // R9
        {12'd600, 12'hFFF, 8'd100, 2'b11, 12'hFFF}   // R10
    };

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [TW-1:0] timeout_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [1:0]    result_o;

    int n_checks = 0;
    int n_fail   = 0;
    int busy_n   = 0;
    int dq5_from = 4095;
    int ret_cnt  = 0;
    int req_cnt  = 0;
    int addr_bad = 0;
    logic          resp_en = 1'b0;
    logic          pend = 1'b0;
    logic [AW-1:0] exp_addr = '0;

    always #4 clk_i = ~clk_i;

    flash_toggle_poller #(.AW(AW), .DW(DW), .TW(TW)) dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .timeout_i  (timeout_i),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    // Status word of read r: bit 6 flips per read while busy, bit 5 from read F on,
    // all other bits vary with r (R12)
    function automatic logic [DW-1:0] status_word(input int r);
        logic [DW-1:0] w;
        int flips;
        flips = (r + 1 < busy_n) ? r + 1 : busy_n;
        w = {r[7:0], ~r[0], 2'b00, r[4:0]};
        w[6] = flips[0];
        w[5] = (r >= dq5_from);
        return w;
    endfunction

    // Flash responder: data returns one cycle after the strobe
    initial begin
        forever begin
            @(negedge clk_i);
            rd_valid_i = pend;
            if (pend) begin
                rd_data_i = status_word(ret_cnt);
                ret_cnt++;
            end
            if (rd_req_o) begin
                req_cnt++;
                if (rd_addr_o != exp_addr) addr_bad++;
            end
            pend = rd_req_o && resp_en;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive start at a falling edge; returns the rising-edge index where done is seen
    task automatic kick(input logic [AW-1:0] a, input logic [TW-1:0] t,
                        input int limit, output int edges);
        addr_i    = a;
        timeout_i = t;
        start_i   = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        edges = 0;
        while (!done_o && edges < limit) begin
            @(negedge clk_i);
            edges++;
        end
        if (!done_o) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: done not seen within %0d cycles", limit);
        end
    endtask

    initial begin
        int edges;
        logic [1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk_i);
        check(!busy_o && !done_o && !rd_req_o && result_o == 2'b00, "R1", "outputs in reset",
              {busy_o, done_o, rd_req_o, result_o}, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        check(!busy_o && !done_o && !rd_req_o && result_o == 2'b00, "R1", "outputs after reset",
              {busy_o, done_o, rd_req_o, result_o}, 0);

        // Vector table
        resp_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            busy_n   = int'(VECS[i][45:34]);
            dq5_from = int'(VECS[i][33:22]);
            ret_cnt  = 0;
            req_cnt  = 0;
            addr_bad = 0;
            exp_addr = AW'(24'h0A5000 + i * 24'h111);
            kick(exp_addr, VECS[i][21:14], 5000, edges);
            check(result_o == VECS[i][13:12], "R3/R4/R5/R6/R7/R9/R10/R12", $sformatf("vec %0d result", i),
                  result_o, VECS[i][13:12]);
            if (VECS[i][11:0] != 12'hFFF)
                check(req_cnt == int'(VECS[i][11:0]), "R2", $sformatf("vec %0d read count", i),
                      req_cnt, VECS[i][11:0]);
            check(addr_bad == 0, "R2", $sformatf("vec %0d read address", i), addr_bad, 0);
            held = result_o;
            @(negedge clk_i);
            check(!done_o, "R11", $sformatf("vec %0d done pulse width", i), done_o, 0);
            repeat (3) @(negedge clk_i);
            check(result_o == held, "R11", $sformatf("vec %0d result held", i), result_o, held);
        end

        // R8: zero timeout, immediate finish with no read
        req_cnt = 0;
        kick(24'h000123, 8'd0, 50, edges);
        check(edges == 0 && result_o == 2'b11, "R8", "zero timeout edge/result", edges * 4 + result_o, 3);
        repeat (3) @(negedge clk_i);
        check(req_cnt == 0, "R8", "no read on zero timeout", req_cnt, 0);

        // R10: no data ever returns; done exactly at edge timeout+2
        resp_en  = 1'b0;
        exp_addr = 24'h00BEEF;
        kick(exp_addr, 8'd5, 100, edges);
        check(edges == 7, "R10", "timeout edge", edges, 7);
        check(result_o == 2'b11, "R10", "timeout code", result_o, 3);
        repeat (2) @(negedge clk_i);

        // R13 and R11: start while busy is ignored; result 00 while polling
        exp_addr  = 24'h00CAFE;
        addr_i    = exp_addr;
        timeout_i = 8'd30;
        start_i   = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check(busy_o && result_o == 2'b00, "R11", "ongoing code while busy", result_o, 0);
        repeat (2) @(negedge clk_i);
        addr_i    = 24'h000777;
        timeout_i = 8'd0;
        start_i   = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check(!done_o && busy_o, "R13", "start while busy ignored", done_o, 0);
        check(rd_addr_o == exp_addr, "R13", "address kept", int'(rd_addr_o), int'(exp_addr));
        edges = 3;
        while (!done_o && edges < 200) begin
            @(negedge clk_i);
            edges++;
        end
        check(edges == 32 && result_o == 2'b11, "R13", "original limit kept", edges, 32);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule